// File: doc/BRIEF.md
# Prioritized Vector Interrupt Controller

This block accepts interrupts for one processor over 256 vectors and decides which to hand over. Each vector has a request bit, an in-service bit and a trigger-mode bit. The vectors fall into classes of 16: the class is the upper four bits of the vector number, and a larger vector number always ranks higher. Other logic raises requests through a vector-set port. Software programs a task priority and a spurious/enable register through a small write port. The processor answers the pending line with an acknowledge strobe and later retires the handler with an end-of-interrupt strobe.

The processor priority combines two inputs: the task priority and the class of the highest vector still in service. The pending line is raised only for a request whose class beats that priority. An acknowledge blocked by the task priority returns the programmable spurious code and changes no state. A counter output reports how many requests arrived while their request bit was clear.

Top module: `vprio_ctrl`

## Requirements
- R1: On a granted acknowledge, the returned vector is the highest-numbered set request bit.
- R2: `ppr` equals the task priority when the task priority's upper nibble is greater than or equal to the class of the highest in-service vector. Otherwise it equals that class followed by four zero bits. An empty in-service set counts as class 0.
- R3: `irq_pend` is 1 only when the unit is enabled and a request exists, and either `ppr` is zero or the top request's class is strictly greater than `ppr[7:4]`.
- R4: The unit is enabled only while bit 8 of the spurious register is 1. A write with `cfg_sel`=1 stores `cfg_wdata[8:0]` and drops the higher bits. While disabled, `irq_pend` is 0 and an acknowledge grants nothing.
- R5: If the task priority is nonzero and the top request is less than or equal to it, an acknowledge raises `ack_spur` and returns the spurious register bits 7:0, and no request or in-service bit changes.
- R6: A granted acknowledge raises `ack_hit`, returns the vector, clears its request bit and sets its in-service bit.
- R7: `eoi` clears the highest set in-service bit, and `irq_pend` and `ppr` follow from the new state.
- R8: Setting a vector with `set_level`=1 marks it level-triggered, and with `set_level`=0 marks it edge-triggered. `ack_level` reports the mark of the granted vector.
- R9: After reset the task priority is 0, all three arrays are empty, the spurious register holds 0xFF (disabled) and `new_cnt` is 0.
- R10: `new_cnt` increments by one only when a set hits a request bit that was clear. A set on an already requested vector leaves it unchanged.
- R11: A set and an acknowledge in the same cycle let the acknowledge see the newly set vector.
- R12: An acknowledge while disabled, or with no request, returns `ack_hit`=0 and `ack_spur`=0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Raise a request this cycle |
| set_vec | input | 8 | Vector to raise |
| set_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = task priority (bits 7:0), 1 = spurious/enable (bits 8:0) |
| cfg_wdata | input | 16 | Write data |
| eoi | input | 1 | End-of-interrupt strobe |
| ack_req | input | 1 | Acknowledge strobe from the processor |
| irq_pend | output | 1 | Interrupt pending toward the processor |
| ack_hit | output | 1 | Acknowledge granted a real vector (same cycle) |
| ack_spur | output | 1 | Acknowledge blocked, spurious code returned |
| ack_vec | output | 8 | Returned vector or spurious code |
| ack_level | output | 1 | Trigger mode of the granted vector |
| ppr | output | 8 | Current processor priority |
| new_cnt | output | 16 | Count of newly raised requests |

## Verification
Every one of the 256 vectors is raised alone and then acknowledged and retired. This shows whether the encoder returns the right index and trigger mark for each vector number, including the class-0 vectors that only pass because `ppr` is zero. A mixed set of vectors drained one acknowledge at a time shows whether the descending order and the stacking of in-service classes into `ppr` are right. A sweep of all sixteen task-priority classes against spread-out vectors separates the strict-greater rule for pending from the less-than-or-equal rule for spurious returns. Simultaneous set and acknowledge, duplicate sets and wide writes to the spurious register cover ordering, counting and field truncation.

// File: rtl/vprio_pkg.sv
package vprio_pkg;
    // Targets selectable on the configuration write port.
    typedef enum logic {
        CFG_TASK_PRI = 1'b0,
        CFG_SPUR     = 1'b1
    } cfg_tgt_e;
endpackage

// File: rtl/vprio_top_bit.sv
// Finds the highest set bit of a vector.
module vprio_top_bit #(
    parameter int W = 256,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (bits_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vprio_ppr.sv
// Combines the task priority with the top in-service class.
module vprio_ppr #(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             isr_any_i,
    input  logic [VEC_W-1:0] isr_top_i,
    output logic [VEC_W-1:0] ppr_o
);
    localparam int SUB_W = VEC_W - CLS_W;

    logic [CLS_W-1:0] isr_cls;

    always_comb begin
        isr_cls = isr_any_i ? isr_top_i[VEC_W-1 -: CLS_W] : '0;
        if (tpr_i[VEC_W-1 -: CLS_W] >= isr_cls)
            ppr_o = tpr_i;
        else
            ppr_o = {isr_cls, {SUB_W{1'b0}}};
    end
endmodule

// File: rtl/vprio_ctrl.sv
module vprio_ctrl #(
    parameter int NUM_VEC = 256,
    parameter int CLS_W   = 4,
    parameter int CFG_W   = 16,
    parameter int CNT_W   = 16,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int SPUR_W = VEC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_valid,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             set_level,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             eoi,
    input  logic             ack_req,
    output logic             irq_pend,
    output logic             ack_hit,
    output logic             ack_spur,
    output logic [VEC_W-1:0] ack_vec,
    output logic             ack_level,
    output logic [VEC_W-1:0] ppr,
    output logic [CNT_W-1:0] new_cnt
);
    import vprio_pkg::*;

    typedef struct packed {
        logic [NUM_VEC-1:0] req;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic [VEC_W-1:0]   tpr;
        logic [SPUR_W-1:0]  svr;
        logic [CNT_W-1:0]   cnt;
    } state_t;

    localparam logic [SPUR_W-1:0] SVR_RST = {1'b0, {VEC_W{1'b1}}};

    state_t state_d, state_q;

    logic [NUM_VEC-1:0] set_mask;
    logic [NUM_VEC-1:0] merged_req;
    logic [NUM_VEC-1:0] merged_tmr;
    logic               mtop_any, rtop_any, itop_any;
    logic [VEC_W-1:0]   mtop_idx, rtop_idx, itop_idx;
    logic               sw_en;
    logic [VEC_W-1:0]   spur_code;
    logic               blocked;
    cfg_tgt_e           cfg_tgt;

    assign set_mask  = set_valid ? ({{(NUM_VEC-1){1'b0}}, 1'b1} << set_vec) : '0;
    assign sw_en     = state_q.svr[SPUR_W-1];
    assign spur_code = state_q.svr[VEC_W-1:0];
    assign cfg_tgt   = cfg_tgt_e'(cfg_sel);

    always_comb begin
        merged_req = state_q.req | set_mask;
        merged_tmr = set_level ? (state_q.tmr | set_mask) : (state_q.tmr & ~set_mask);
    end

    vprio_top_bit #(.W(NUM_VEC)) u_merged (
        .bits_i(merged_req), .any_o(mtop_any), .idx_o(mtop_idx));
    vprio_top_bit #(.W(NUM_VEC)) u_req (
        .bits_i(state_q.req), .any_o(rtop_any), .idx_o(rtop_idx));
    vprio_top_bit #(.W(NUM_VEC)) u_isr (
        .bits_i(state_q.isr), .any_o(itop_any), .idx_o(itop_idx));

    vprio_ppr #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_ppr (
        .tpr_i(state_q.tpr), .isr_any_i(itop_any), .isr_top_i(itop_idx), .ppr_o(ppr));

    // Pending follows registered state only.
    always_comb begin
        irq_pend = sw_en && rtop_any &&
                   ((ppr == '0) || (rtop_idx[VEC_W-1 -: CLS_W] > ppr[VEC_W-1 -: CLS_W]));
    end

    // Acknowledge decision, seeing a set from the same cycle.
    always_comb begin
        blocked   = (state_q.tpr != '0) && (mtop_idx <= state_q.tpr);
        ack_hit   = ack_req && sw_en && mtop_any && !blocked;
        ack_spur  = ack_req && sw_en && mtop_any && blocked;
        ack_vec   = ack_hit ? mtop_idx : (ack_spur ? spur_code : '0);
        ack_level = ack_hit && merged_tmr[mtop_idx];
    end

    always_comb begin
        state_d     = state_q;
        state_d.req = merged_req;
        state_d.tmr = set_valid ? merged_tmr : state_q.tmr;
        if (set_valid && !state_q.req[set_vec])
            state_d.cnt = state_q.cnt + 1'b1;
        if (eoi && itop_any)
            state_d.isr[itop_idx] = 1'b0;
        if (ack_hit) begin
            state_d.req[mtop_idx] = 1'b0;
            state_d.isr[mtop_idx] = 1'b1;
        end
        if (cfg_we) begin
            if (cfg_tgt == CFG_SPUR)
                state_d.svr = cfg_wdata[SPUR_W-1:0];
            else
                state_d.tpr = cfg_wdata[VEC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.req <= '0;
            state_q.isr <= '0;
            state_q.tmr <= '0;
            state_q.tpr <= '0;
            state_q.svr <= SVR_RST;
            state_q.cnt <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign new_cnt = state_q.cnt;
endmodule

// File: rtl/vprio_ctrl_chk.sv
module vprio_ctrl_chk #(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_pend,
    input logic             ack_hit,
    input logic             ack_spur,
    input logic [VEC_W-1:0] ack_vec,
    input logic [VEC_W-1:0] ppr,
    input logic [CNT_W-1:0] new_cnt,
    input logic             eoi,
    input logic             cfg_we,
    input logic             sw_en,
    input logic [VEC_W-1:0] spur_code
);
    p_hit_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |-> sw_en);

    p_pend_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> sw_en);

    p_spur_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_spur |-> (ack_vec == spur_code));

    p_spur_keeps_ppr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_spur && !eoi && !cfg_we) |=> $stable(ppr));

    p_hit_lifts_ppr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> (ppr[VEC_W-1 -: CLS_W] >= $past(ack_vec[VEC_W-1 -: CLS_W])));

    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((new_cnt == $past(new_cnt)) || (new_cnt == $past(new_cnt) + 1'b1)));

    p_ack_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_hit && ack_spur));
endmodule

bind vprio_ctrl vprio_ctrl_chk #(.VEC_W(VEC_W), .CLS_W(CLS_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .ack_hit(ack_hit),
    .ack_spur(ack_spur), .ack_vec(ack_vec), .ppr(ppr), .new_cnt(new_cnt),
    .eoi(eoi), .cfg_we(cfg_we), .sw_en(sw_en), .spur_code(spur_code));

// File: tb/sim_vprio_ctrl.sv
module sim_vprio_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_valid = 1'b0, set_level = 1'b0;
    logic [7:0]  set_vec = '0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        eoi = 1'b0, ack_req = 1'b0;
    logic        irq_pend, ack_hit, ack_spur, ack_level;
    logic [7:0]  ack_vec, ppr;
    logic [15:0] new_cnt;

    int n_chk = 0, n_bad = 0;

    // Bench model state, derived from the requirements
    logic [255:0] m_req = '0, m_isr = '0, m_tmr = '0;
    logic [7:0]   m_tpr = '0;
    logic [8:0]   m_svr = 9'h0FF;
    int           m_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    vprio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vec(set_vec),
        .set_level(set_level), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .eoi(eoi), .ack_req(ack_req),
        .irq_pend(irq_pend), .ack_hit(ack_hit), .ack_spur(ack_spur),
        .ack_vec(ack_vec), .ack_level(ack_level), .ppr(ppr), .new_cnt(new_cnt));

    function automatic int top_of(logic [255:0] a);
        for (int i = 255; i >= 0; i--) if (a[i]) return i;
        return -1;
    endfunction

    function automatic int exp_ppr();
        int c = top_of(m_isr);
        c = (c < 0) ? 0 : (c >> 4);
        return ((m_tpr >> 4) >= c) ? int'(m_tpr) : (c << 4);
    endfunction

    function automatic int exp_pend();
        int t = top_of(m_req);
        int p = exp_ppr();
        if (!m_svr[8] || t < 0) return 0;
        return (p == 0 || (t >> 4) > (p >> 4)) ? 1 : 0;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " R3 pend"}, int'(irq_pend), exp_pend());
        chk({tag, " R2 ppr"}, int'(ppr), exp_ppr());
        chk({tag, " R10 count"}, int'(new_cnt), m_cnt & 16'hFFFF);
    endtask

    // One cycle of stimulus; starts and ends at a falling edge.
    task automatic step(input bit sv, input int vec, input bit lvl, input bit we,
                        input bit sel, input int wd, input bit e, input bit ak,
                        input string tag);
        logic [255:0] mreq, mtmr;
        int  top, it;
        bit  hit, spur;
        set_valid = sv; set_vec = vec[7:0]; set_level = lvl;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd[15:0];
        eoi = e; ack_req = ak;
        #1;
        mreq = m_req; mtmr = m_tmr;
        if (sv) begin
            mreq[vec] = 1'b1;
            mtmr[vec] = lvl;
        end
        top  = top_of(mreq);
        hit  = 0; spur = 0;
        if (ak && m_svr[8] && top >= 0) begin
            if (m_tpr != 0 && top <= int'(m_tpr)) spur = 1;
            else hit = 1;
        end
        if (ak) begin
            chk({tag, " R6 R12 ack_hit"}, int'(ack_hit), int'(hit));
            chk({tag, " R5 R12 ack_spur"}, int'(ack_spur), int'(spur));
            if (hit) begin
                chk({tag, " R1 R6 vector"}, int'(ack_vec), top);
                chk({tag, " R8 level"}, int'(ack_level), int'(mtmr[top]));
            end
            if (spur) chk({tag, " R5 spurious code"}, int'(ack_vec), int'(m_svr[7:0]));
        end
        if (sv && !m_req[vec]) m_cnt++;
        it = top_of(m_isr);
        m_req = mreq; m_tmr = mtmr;
        if (e && it >= 0) m_isr[it] = 1'b0;
        if (hit) begin
            m_req[top] = 1'b0;
            m_isr[top] = 1'b1;
        end
        if (we) begin
            if (sel) m_svr = wd[8:0];
            else m_tpr = wd[7:0];
        end
        @(posedge clk);
        @(negedge clk);
        set_valid = 0; cfg_we = 0; eoi = 0; ack_req = 0;
        check_regs(tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_regs("R9 reset");
        chk("R9 pend after reset", int'(irq_pend), 0);
        chk("R9 ppr after reset", int'(ppr), 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, "R12 empty ack");

        // Disabled: request latches but no pend, no grant
        step(1, 8'h40, 0, 0, 0, 0, 0, 0, "R4 set while disabled");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R4 R12 ack while disabled");
        step(0, 0, 0, 1, 1, 16'h01FF, 0, 0, "R4 enable");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R6 take 0x40");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R7 retire 0x40");

        // Every vector alone
        for (int v = 0; v < 256; v++) begin
            step(1, v, v[0], 0, 0, 0, 0, 0, "R3 R8 single set");
            step(0, 0, 0, 0, 0, 0, 0, 1, "R6 R8 single ack");
            step(0, 0, 0, 0, 0, 0, 1, 0, "R7 single eoi");
        end

        // Ordering among several requests, then stacked retirement
        step(1, 3, 1, 0, 0, 0, 0, 0, "R1 load");
        step(1, 77, 0, 0, 0, 0, 0, 0, "R1 load");
        step(1, 200, 1, 0, 0, 0, 0, 0, "R1 load");
        step(1, 129, 0, 0, 0, 0, 0, 0, "R1 load");
        step(1, 16, 1, 0, 0, 0, 0, 0, "R1 load");
        step(1, 77, 1, 0, 0, 0, 0, 0, "R10 R8 duplicate set");
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0, 0, 0, 1, "R1 R2 drain order");
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0, 0, 1, 0, "R7 R2 stacked eoi");

        // Task priority sweep over all classes
        for (int t = 0; t < 16; t++) begin
            for (int k = 0; k < 16; k++) begin
                step(0, 0, 0, 1, 0, (t << 4) | 5, 0, 0, "R2 tpr write");
                step(1, (k * 17 + t * 5) & 255, k[0], 0, 0, 0, 0, 0, "R3 tpr set");
                step(0, 0, 0, 0, 0, 0, 0, 1, "R5 R6 tpr ack");
                step(0, 0, 0, 0, 0, 0, 1, 0, "R7 tpr eoi");
            end
        end
        step(0, 0, 0, 1, 0, 0, 0, 0, "R2 tpr clear");
        for (int k = 0; k < 300; k++) begin
            step(0, 0, 0, 0, 0, 0, 0, 1, "R1 drain");
            step(0, 0, 0, 0, 0, 0, 1, 0, "R7 drain eoi");
        end

        // Set and acknowledge in the same cycle
        step(1, 90, 1, 0, 0, 0, 0, 1, "R11 same cycle");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R11 retire");

        // Wide write to the spurious register
        step(0, 0, 0, 1, 1, 16'h0E7A, 0, 0, "R4 truncated write disables");
        step(1, 150, 0, 0, 0, 0, 0, 0, "R4 set while disabled");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R4 ack while disabled");
        step(0, 0, 0, 1, 1, 16'hF1F3, 0, 0, "R4 re-enable");
        step(0, 0, 0, 1, 0, 16'h00C0, 0, 0, "R5 tpr above");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R5 blocked ack");
        step(0, 0, 0, 1, 0, 16'h0096, 0, 0, "R5 tpr equal");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R5 equal blocked");
        step(0, 0, 0, 1, 0, 16'h0095, 0, 0, "R5 tpr below");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R6 now granted");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule